// File: doc/BRIEF.md
# Windowed Address Translator

The block moves request addresses from one address map into another through a small set of programmable windows. Each window is a naturally aligned, power-of-two sized region of the source map, paired with a translation value. An address that falls inside an enabled window leaves the block as its offset into that window plus the translation value. A small window can therefore land on a target range anywhere in the destination map. An address that falls in no enabled window comes out flagged as a miss, so the consumer can answer with an error.

Two independent channels sit side by side. The downstream channel maps host-side addresses onto the local bus. The upstream channel maps local-bus addresses onto host addresses. Each channel has four windows and a valid/ready request stream in and out. One shared write-only register port programs the windows of both channels. The result is registered, so a request accepted on one clock edge is offered at the output from the next edge onward.

Top module: `bxl_top`

## Requirements
- R1: A window hits only when its enable is set and the request address lies from the aligned base up to aligned base + 2^size − 1, both ends included.
- R2: On a hit, the output address is (request address − aligned base + translation value) modulo 2^32.
- R3: When several enabled windows match, the result reports the lowest-numbered one in `*_out_win` and uses its translation.
- R4: On a miss, the result has `*_out_miss`=1, `*_out_hit`=0, `*_out_addr`=0 and `*_out_win`=0. On a hit, `*_out_hit`=1 and `*_out_miss`=0.
- R5: A control write (`cfg_sel`=0) sets enable from `cfg_wdata[0]` and log2 of the window size from `cfg_wdata[13:8]`. Values below 12 act as 12, and values above 32 act as 32 (the whole map).
- R6: The base (`cfg_sel`=1) is taken with the bits below the window size forced to zero. A misaligned base acts as the aligned base beneath it.
- R7: A disabled window never hits, whatever its base, size and translation.
- R8: `*_in_ready` = !`*_out_valid` | `*_out_ready`. A request accepted on an edge is valid at the output after that edge. While `*_out_valid`=1 and `*_out_ready`=0, the output holds unchanged.
- R9: `cfg_dir`=0 selects the downstream channel's windows and `cfg_dir`=1 the upstream channel's. Writes to one channel leave the other's translation unchanged.
- R10: After reset, both outputs are not valid, both inputs are ready, and every window is disabled, so every request misses.
- R11: A write with `cfg_sel`=3 changes no window. `cfg_sel`=2 writes the translation value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_dir | input | 1 | 0 downstream channel, 1 upstream channel |
| cfg_win | input | 2 | Window number |
| cfg_sel | input | 2 | 0 control, 1 base, 2 translation, 3 none |
| cfg_wdata | input | 32 | Write data |
| dn_in_valid | input | 1 | Downstream request valid |
| dn_in_ready | output | 1 | Downstream request ready |
| dn_in_addr | input | 32 | Downstream request address |
| dn_out_valid | output | 1 | Downstream result valid |
| dn_out_ready | input | 1 | Downstream result ready |
| dn_out_addr | output | 32 | Downstream translated address |
| dn_out_hit | output | 1 | Downstream window hit |
| dn_out_miss | output | 1 | Downstream miss |
| dn_out_win | output | 2 | Downstream hitting window |
| up_in_valid | input | 1 | Upstream request valid |
| up_in_ready | output | 1 | Upstream request ready |
| up_in_addr | input | 32 | Upstream request address |
| up_out_valid | output | 1 | Upstream result valid |
| up_out_ready | input | 1 | Upstream result ready |
| up_out_addr | output | 32 | Upstream translated address |
| up_out_hit | output | 1 | Upstream window hit |
| up_out_miss | output | 1 | Upstream miss |
| up_out_win | output | 2 | Upstream hitting window |

## Verification
The bench probes both ends of a window: the last byte inside it and the first byte past it. A design with an off-by-one size compare would hit on the byte past the end or miss on the last byte. Overlapping windows check priority, and an inverted priority encoder would report window 1 where window 0 is due. A misaligned base, an undersized and an oversized size code, a translation that wraps past 2^32, and a stalled output are each driven. A design that kept raw base bits would shift the offset. One that skipped the clamps would shrink or break its window. One that lost the hold would drop or alter a result under backpressure.

// File: rtl/bxl_pkg.sv
package bxl_pkg;
  localparam int ADDR_W = 32;
  localparam int L2_W   = 6;

  typedef struct packed {
    logic              en;
    logic [L2_W-1:0]   l2;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] xl;
  } win_t;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BASE = 2'd1,
    SEL_XL   = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;
endpackage

// File: rtl/bxl_win_regs.sv
module bxl_win_regs
  import bxl_pkg::*;
#(
  parameter int NWIN   = 4,
  parameter int MIN_L2 = 12,
  localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [IDX_W-1:0]      widx,
  input  logic [1:0]            sel,
  input  logic [ADDR_W-1:0]     wdata,
  output win_t [NWIN-1:0]       wins
);
  localparam logic [L2_W-1:0] L2_LO = L2_W'(MIN_L2);
  localparam logic [L2_W-1:0] L2_HI = L2_W'(ADDR_W);

  logic [L2_W-1:0] l2_raw;
  logic [L2_W-1:0] l2_fit;

  // size code clamped into the legal range R5
  always_comb begin
    l2_raw = wdata[8 +: L2_W];
    if (l2_raw < L2_LO)      l2_fit = L2_LO;
    else if (l2_raw > L2_HI) l2_fit = L2_HI;
    else                     l2_fit = l2_raw;
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        wins[i].en   <= 1'b0;
        wins[i].l2   <= L2_LO;
        wins[i].base <= '0;
        wins[i].xl   <= '0;
      end else if (we && (widx == IDX_W'(i))) begin
        case (sel_e'(sel))
          SEL_CTRL: begin
            wins[i].en <= wdata[0];
            wins[i].l2 <= l2_fit;
          end
          SEL_BASE: wins[i].base <= wdata;
          SEL_XL:   wins[i].xl   <= wdata;
          default:  ;
        endcase
      end
    end

    AST_L2_LEGAL: assert property (@(posedge clk) disable iff (rst)
      (wins[i].l2 >= L2_LO) && (wins[i].l2 <= L2_HI)); // R5
  end
endmodule

// File: rtl/bxl_match.sv
module bxl_match
  import bxl_pkg::*;
#(
  parameter int NWIN = 4,
  localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  win_t [NWIN-1:0]   wins,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] xaddr
);
  logic [NWIN-1:0]             hv;
  logic [NWIN-1:0][ADDR_W-1:0] xa;

  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] abase;
    always_comb begin
      if (wins[i].l2 >= L2_W'(ADDR_W)) mask = '1;
      else mask = (ADDR_W'(1) << wins[i].l2) - ADDR_W'(1);
      abase = wins[i].base & ~mask;
      hv[i] = wins[i].en && (((addr ^ abase) & ~mask) == '0);
      xa[i] = (addr - abase) + wins[i].xl;
    end
  end

  // lowest index wins: scan from the top down so index 0 lands last
  always_comb begin
    hit   = 1'b0;
    idx   = '0;
    xaddr = '0;
    for (int j = NWIN - 1; j >= 0; j--) begin
      if (hv[j]) begin
        hit   = 1'b1;
        idx   = IDX_W'(j);
        xaddr = xa[j];
      end
    end
  end
endmodule

// File: rtl/bxl_pipe.sv
module bxl_pipe
  import bxl_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              m_hit,
  input  logic [IDX_W-1:0]  m_idx,
  input  logic [ADDR_W-1:0] m_xaddr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_hit,
  output logic              out_miss,
  output logic [IDX_W-1:0]  out_win
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_hit   <= 1'b0;
      out_miss  <= 1'b0;
      out_win   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_hit   <= m_hit;
      out_miss  <= !m_hit;
      out_win   <= m_hit ? m_idx : '0;
      out_addr  <= m_hit ? m_xaddr : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
      $stable(out_win) && $stable(out_miss))); // R8
  AST_FLAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_hit != out_miss)); // R4
  AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_miss) |-> (out_addr == '0 && out_win == '0)); // R4
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid); // R10
endmodule

// File: rtl/bxl_chan.sv
module bxl_chan
  import bxl_pkg::*;
#(
  parameter int NWIN   = 4,
  parameter int MIN_L2 = 12,
  localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_hit,
  output logic              out_miss,
  output logic [IDX_W-1:0]  out_win
);
  win_t [NWIN-1:0]   wins;
  logic              m_hit;
  logic [IDX_W-1:0]  m_idx;
  logic [ADDR_W-1:0] m_xaddr;

  bxl_win_regs #(.NWIN(NWIN), .MIN_L2(MIN_L2)) u_regs (
    .clk(clk), .rst(rst), .we(we), .widx(widx), .sel(sel),
    .wdata(wdata), .wins(wins)
  );

  bxl_match #(.NWIN(NWIN)) u_match (
    .addr(in_addr), .wins(wins), .hit(m_hit), .idx(m_idx), .xaddr(m_xaddr)
  );

  bxl_pipe #(.IDX_W(IDX_W)) u_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .m_hit(m_hit), .m_idx(m_idx), .m_xaddr(m_xaddr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_hit(out_hit), .out_miss(out_miss), .out_win(out_win)
  );
endmodule

// File: rtl/bxl_top.sv
module bxl_top
  import bxl_pkg::*;
#(
  parameter int NWIN   = 4,
  parameter int MIN_L2 = 12,
  localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_dir,
  input  logic [IDX_W-1:0]  cfg_win,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              dn_in_valid,
  output logic              dn_in_ready,
  input  logic [ADDR_W-1:0] dn_in_addr,
  output logic              dn_out_valid,
  input  logic              dn_out_ready,
  output logic [ADDR_W-1:0] dn_out_addr,
  output logic              dn_out_hit,
  output logic              dn_out_miss,
  output logic [IDX_W-1:0]  dn_out_win,
  input  logic              up_in_valid,
  output logic              up_in_ready,
  input  logic [ADDR_W-1:0] up_in_addr,
  output logic              up_out_valid,
  input  logic              up_out_ready,
  output logic [ADDR_W-1:0] up_out_addr,
  output logic              up_out_hit,
  output logic              up_out_miss,
  output logic [IDX_W-1:0]  up_out_win
);
  // R9: the direction bit steers the write strobe to one channel only
  logic dn_we, up_we;
  assign dn_we = cfg_we && !cfg_dir;
  assign up_we = cfg_we &&  cfg_dir;

  bxl_chan #(.NWIN(NWIN), .MIN_L2(MIN_L2)) u_dn (
    .clk(clk), .rst(rst), .we(dn_we), .widx(cfg_win), .sel(cfg_sel),
    .wdata(cfg_wdata), .in_valid(dn_in_valid), .in_ready(dn_in_ready),
    .in_addr(dn_in_addr), .out_valid(dn_out_valid), .out_ready(dn_out_ready),
    .out_addr(dn_out_addr), .out_hit(dn_out_hit), .out_miss(dn_out_miss),
    .out_win(dn_out_win)
  );

  bxl_chan #(.NWIN(NWIN), .MIN_L2(MIN_L2)) u_up (
    .clk(clk), .rst(rst), .we(up_we), .widx(cfg_win), .sel(cfg_sel),
    .wdata(cfg_wdata), .in_valid(up_in_valid), .in_ready(up_in_ready),
    .in_addr(up_in_addr), .out_valid(up_out_valid), .out_ready(up_out_ready),
    .out_addr(up_out_addr), .out_hit(up_out_hit), .out_miss(up_out_miss),
    .out_win(up_out_win)
  );
endmodule

// File: tb/tb_bxl_top.sv
`timescale 1ns/1ps
module tb_bxl_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_dir = 1'b0;
  logic [1:0]  cfg_win = '0, cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        dn_in_valid = 1'b0, dn_out_ready = 1'b1;
  logic        up_in_valid = 1'b0, up_out_ready = 1'b1;
  logic [31:0] dn_in_addr = '0, up_in_addr = '0;
  logic        dn_in_ready, dn_out_valid, dn_out_hit, dn_out_miss;
  logic        up_in_ready, up_out_valid, up_out_hit, up_out_miss;
  logic [31:0] dn_out_addr, up_out_addr;
  logic [1:0]  dn_out_win, up_out_win;

  always #5 clk = ~clk;

  bxl_top dut (.*);

  typedef struct packed { logic hit; logic [1:0] win; logic [31:0] addr; } res_t;
  res_t  q_dn[$], q_up[$];
  string t_dn[$], t_up[$];
  int n_chk = 0, n_bad = 0;

  // bench model of the windows, built from the requirements
  logic        m_en[2][4];
  logic [5:0]  m_l2[2][4];
  logic [31:0] m_base[2][4], m_xl[2][4];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic res_t predict(input int d, input logic [31:0] a);
    res_t r;
    r = '0;
    for (int i = 3; i >= 0; i--) begin
      logic [63:0] mask;
      logic [31:0] ab;
      mask = (64'd1 << m_l2[d][i]) - 64'd1;
      ab = m_base[d][i] & ~mask[31:0];
      if (m_en[d][i] && ((a & ~mask[31:0]) == ab)) begin
        r.hit = 1'b1; r.win = 2'(i); r.addr = a - ab + m_xl[d][i];
      end
    end
    return r;
  endfunction

  task automatic cfg(input int d, input int w, input int s, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dir = d[0]; cfg_win = 2'(w); cfg_sel = 2'(s); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (s == 0) begin
      logic [5:0] raw;
      raw = v[13:8];
      m_en[d][w] = v[0];
      m_l2[d][w] = (raw < 6'd12) ? 6'd12 : (raw > 6'd32) ? 6'd32 : raw;
    end else if (s == 1) m_base[d][w] = v;
    else if (s == 2) m_xl[d][w] = v;
  endtask

  task automatic send(input int d, input logic [31:0] a, input string tag);
    res_t e;
    e = predict(d, a);
    @(negedge clk);
    if (d == 0) begin
      q_dn.push_back(e); t_dn.push_back(tag);
      dn_in_valid = 1'b1; dn_in_addr = a;
      #1; while (!dn_in_ready) begin @(negedge clk); #1; end
      @(negedge clk); dn_in_valid = 1'b0;
    end else begin
      q_up.push_back(e); t_up.push_back(tag);
      up_in_valid = 1'b1; up_in_addr = a;
      #1; while (!up_in_ready) begin @(negedge clk); #1; end
      @(negedge clk); up_in_valid = 1'b0;
    end
  endtask

  // monitors: pop and compare on every accepted result
  always @(negedge clk) begin
    #2;
    if (!rst && dn_out_valid && dn_out_ready) begin
      if (q_dn.size() == 0) check("R8 dn unexpected result", 1, 0);
      else begin
        res_t e; string t;
        e = q_dn.pop_front(); t = t_dn.pop_front();
        check(t, {dn_out_hit, dn_out_miss, dn_out_win, dn_out_addr},
                 {e.hit, !e.hit, e.win, e.addr});
      end
    end
    if (!rst && up_out_valid && up_out_ready) begin
      if (q_up.size() == 0) check("R8 up unexpected result", 1, 0);
      else begin
        res_t e; string t;
        e = q_up.pop_front(); t = t_up.pop_front();
        check(t, {up_out_hit, up_out_miss, up_out_win, up_out_addr},
                 {e.hit, !e.hit, e.win, e.addr});
      end
    end
  end

  initial begin
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 4; i++) begin
        m_en[d][i] = 1'b0; m_l2[d][i] = 6'd12; m_base[d][i] = '0; m_xl[d][i] = '0;
      end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R10 reset outputs", {dn_out_valid, up_out_valid, dn_in_ready, up_in_ready}, 4'b0011);
    send(0, 32'h1234_5678, "R10 dn miss after reset");
    send(1, 32'h0000_0000, "R10 up miss after reset");

    cfg(0, 0, 0, 32'h0000_0E01);
    cfg(0, 0, 1, 32'hF000_0000);
    cfg(0, 0, 2, 32'h0900_0000);
    send(0, 32'hF000_0100, "R2 translated hit");
    send(0, 32'hF000_3FFF, "R1 last byte inside");
    send(0, 32'hF000_4000, "R1 first byte past end");
    send(0, 32'hEFFF_FFFF, "R4 below base miss");

    cfg(0, 1, 0, 32'h0000_1C01);
    cfg(0, 1, 1, 32'hF000_0000);
    send(0, 32'hF900_0100, "R2 untranslated large window");
    send(0, 32'hF000_0200, "R3 overlap lowest wins");

    cfg(0, 2, 0, 32'h0000_0C01);
    cfg(0, 2, 1, 32'h1234_5678);
    cfg(0, 2, 2, 32'h8000_0000);
    send(0, 32'h1234_5010, "R6 misaligned base");

    cfg(0, 3, 0, 32'h0000_0501);
    cfg(0, 3, 1, 32'h2000_0000);
    send(0, 32'h2000_0FFF, "R5 small size clamped up");
    send(0, 32'h2000_1000, "R5 clamped window end");
    cfg(0, 3, 2, 32'hFFFF_FF00);
    send(0, 32'h2000_0200, "R2 wraparound");

    cfg(0, 0, 0, 32'h0000_0E00);
    send(0, 32'hF000_0100, "R7 disabled window skipped");
    cfg(0, 1, 3, 32'hFFFF_FFFF);
    send(0, 32'hF000_0100, "R11 no-op select");

    cfg(1, 0, 0, 32'h0000_2801);
    cfg(1, 0, 2, 32'h4000_0000);
    send(1, 32'h1234_5678, "R5 oversize whole map");
    send(0, 32'h1234_5010, "R9 dn untouched by up write");

    // backpressure on the downstream output
    @(negedge clk); dn_out_ready = 1'b0;
    begin
      res_t e;
      e = predict(0, 32'h1234_5020);
      send(0, 32'h1234_5020, "R8 held result");
      repeat (3) @(negedge clk);
      #1;
      check("R8 stall valid/ready", {dn_out_valid, dn_in_ready}, 2'b10);
      check("R8 stall holds addr", dn_out_addr, e.addr);
    end
    @(negedge clk); dn_out_ready = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 queues drained", q_dn.size() + q_up.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule